// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Condition Flags

This block is a purely combinational arithmetic-logic unit. It takes two operands of a parameterised width and a three-bit operation code, and it returns a result of the same width. It also returns four condition flags: negative, zero, carry and overflow. The supported operations are addition, subtraction, bitwise AND, OR and XOR, and a single-position logical left shift.

Subtraction runs on the same adder as addition. The second operand is inverted and the adder's incoming carry is forced high. Every operation applies its own flag rules:

- Arithmetic operations report the unsigned carry and the signed overflow separately.
- Logic operations clear both carry and overflow.
- The shift puts the bit that leaves the top of the word on the carry flag.

Outputs settle from the current inputs alone. The block holds no state, so any flag storage lives with whoever consumes these outputs.

Top module: `alu_nzcv`

## Requirements
- R1: Code 3'b000 (add) returns the sum of the two operands modulo 2^WIDTH.
- R2: For add, the carry flag is the carry out of the most significant bit, which is 1 exactly when the unsigned sum is 2^WIDTH or more.
- R3: Code 3'b001 (subtract) returns A minus B modulo 2^WIDTH, formed as A plus the bitwise inverse of B plus one.
- R4: For subtract, the carry flag is 1 when A is greater than or equal to B as unsigned values, and 0 when a borrow occurs.
- R5: For add and subtract, the overflow flag is 1 exactly when the signed result falls outside the WIDTH-bit two's-complement range. This is the carry into the sign bit XOR the carry out of it.
- R6: Codes 3'b010 (AND), 3'b011 (OR) and 3'b100 (XOR) return the bitwise result, and they force carry and overflow to 0.
- R7: Code 3'b101 (left shift) returns A shifted up by one place, with 0 entering bit 0. Carry is A's most significant bit, and overflow is 0.
- R8: For every code, the zero flag is 1 exactly when all result bits are 0.
- R9: For every code, the negative flag equals the most significant bit of the result.
- R10: Codes 3'b110 and 3'b111 return a result of 0 with carry, overflow and negative at 0, and zero at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | WIDTH | Operation result |
| flag_n | output | 1 | Negative: most significant result bit |
| flag_z | output | 1 | Zero: result is all zeros |
| flag_c | output | 1 | Carry, not-borrow, or shifted-out bit |
| flag_v | output | 1 | Signed overflow |

## Verification
Because the block has no state, a faulty carry chain or operand inversion shows on the very vector that exercises it. It appears as a wrong result bit, or as a carry or overflow flag that disagrees with the unsigned and signed interpretations of the operands. A misrouted select decode shows as one operation's result or flag rules appearing under another code. Directed vectors cover the boundaries where carry and overflow part ways, including equal operands on subtract and the sign-bit crossings. Seeded random pairs under every code, including the two unused ones, fill in the rest.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4,
      OP_SHL = 3'd5
   } alu_op_e;

   typedef enum logic [1:0] {
      BW_AND = 2'd0,
      BW_OR  = 2'd1,
      BW_XOR = 2'd2,
      BW_NONE = 2'd3
   } bw_sel_e;

   function automatic logic op_is_arith(input logic [2:0] code);
      return (code == OP_ADD) || (code == OP_SUB);
   endfunction

   function automatic logic op_is_bitwise(input logic [2:0] code);
      return (code == OP_AND) || (code == OP_OR) || (code == OP_XOR);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             carry_msb_in,
   output logic             carry_out
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   assign b_eff = b ^ {WIDTH{sub}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_addsub: WIDTH must be at least 2");
      end

      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = sub;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic half;
            assign half       = a[i] ^ b_eff[i];
            assign sum[i]     = half ^ chain[i];
            assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & half);
         end
         assign carry_msb_in = chain[MSB];
         assign carry_out    = chain[WIDTH];
      end else begin : g_split
         logic [MSB:0] low;
         logic [1:0]   top;
         assign low = {1'b0, a[MSB-1:0]} + {1'b0, b_eff[MSB-1:0]} + {{MSB{1'b0}}, sub};
         assign carry_msb_in = low[MSB];
         assign top = {1'b0, a[MSB]} + {1'b0, b_eff[MSB]} + {1'b0, low[MSB]};
         assign sum       = {top[0], low[MSB-1:0]};
         assign carry_out = top[1];
      end
   endgenerate

   logic [WIDTH:0] wide_ref;
   always_comb begin
      wide_ref = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
      AST_ADDER_SUM: assert ({carry_out, sum} == wide_ref) else $error("adder sum mismatch"); // R1
   end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]          a,
   input  logic [WIDTH-1:0]          b,
   input  alu_nzcv_pkg::bw_sel_e     sel,
   output logic [WIDTH-1:0]          res
);
   import alu_nzcv_pkg::*;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_lane
         always_comb begin
            case (sel)
               BW_AND:  res[i] = a[i] & b[i];
               BW_OR:   res[i] = a[i] | b[i];
               BW_XOR:  res[i] = a[i] ^ b[i];
               default: res[i] = 1'b0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/alu_shl.sv
module alu_shl #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   output logic [WIDTH-1:0] res,
   output logic             out_bit
);
   localparam int MSB = WIDTH - 1;

   assign res     = {a[MSB-1:0], 1'b0};
   assign out_bit = a[MSB];

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] res,
   output logic             neg,
   output logic             zero
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] any_set;
   assign any_set[0] = res[0];
   generate
      for (genvar i = 1; i < WIDTH; i++) begin : g_or
         assign any_set[i] = any_set[i-1] | res[i];
      end
   endgenerate

   assign zero = ~any_set[MSB];
   assign neg  = res[MSB];

endmodule

// File: rtl/alu_nzcv.sv
module alu_nzcv #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [2:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c,
   output logic             flag_v
);
   import alu_nzcv_pkg::*;

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] add_sum, bw_res, shl_res;
   logic             add_cin_msb, add_cout, shl_out;
   bw_sel_e          bw_sel;

   alu_addsub #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_addsub (
      .a            (op_a),
      .b            (op_b),
      .sub          (op_sel == OP_SUB),
      .sum          (add_sum),
      .carry_msb_in (add_cin_msb),
      .carry_out    (add_cout)
   );

   always_comb begin
      case (op_sel)
         OP_AND:  bw_sel = BW_AND;
         OP_OR:   bw_sel = BW_OR;
         OP_XOR:  bw_sel = BW_XOR;
         default: bw_sel = BW_NONE;
      endcase
   end

   alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .a   (op_a),
      .b   (op_b),
      .sel (bw_sel),
      .res (bw_res)
   );

   alu_shl #(.WIDTH(WIDTH)) u_shl (
      .a       (op_a),
      .res     (shl_res),
      .out_bit (shl_out)
   );

   always_comb begin
      result = '0;
      flag_c = 1'b0;
      flag_v = 1'b0;
      if (op_is_arith(op_sel)) begin
         result = add_sum;
         flag_c = add_cout;
         flag_v = add_cin_msb ^ add_cout;
      end else if (op_is_bitwise(op_sel)) begin
         result = bw_res;
      end else if (op_sel == OP_SHL) begin
         result = shl_res;
         flag_c = shl_out;
      end
   end

   alu_flags #(.WIDTH(WIDTH)) u_flags (
      .res  (result),
      .neg  (flag_n),
      .zero (flag_z)
   );

   always_comb begin
      if (op_sel == OP_SUB) begin
         AST_SUB_NOT_BORROW: assert (flag_c == (op_a >= op_b)) else $error("sub carry wrong"); // R4
      end
      if (op_is_arith(op_sel)) begin
         AST_SIGNED_OVF: assert (flag_v == ((op_a[MSB] == (op_b[MSB] ^ (op_sel == OP_SUB))) && (result[MSB] != op_a[MSB]))) else $error("overflow wrong"); // R5
      end
      if (op_is_bitwise(op_sel)) begin
         AST_LOGIC_CV_CLEAR: assert (!flag_c && !flag_v) else $error("logic op left C/V set"); // R6
      end
      if (op_sel == OP_SHL) begin
         AST_SHL_OUT: assert (flag_c == op_a[MSB] && !flag_v && result[0] == 1'b0) else $error("shift flags wrong"); // R7
      end
      if (op_sel[2:1] == 2'b11) begin
         AST_UNUSED_CODE: assert (result == '0 && !flag_c && !flag_v && flag_z) else $error("unused code not quiet"); // R10
      end
   end

endmodule

// File: tb/test_alu_nzcv.sv
module test_alu_nzcv;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int RAND_PER_CODE = 3000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [W-1:0] op_a = '0, op_b = '0, result;
   logic [2:0]   op_sel = 3'd0;
   logic         flag_n, flag_z, flag_c, flag_v;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   alu_nzcv #(.WIDTH(W)) i_alu_nzcv (
      .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .result(result), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v)
   );

   // Reference: returns {res, n, z, c, v}
   function automatic logic [W+3:0] model(input logic [2:0] code, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] r;
      logic c, v;
      int unsigned ua, ub;
      ua = a; ub = b;
      r = '0; c = 1'b0; v = 1'b0;
      case (code)
         3'd0: begin
            r = W'(ua + ub);
            c = (ua + ub) >= (1 << W);
            v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
         end
         3'd1: begin
            r = W'(ua - ub);
            c = ua >= ub;
            v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
         end
         3'd2: r = a & b;
         3'd3: r = a | b;
         3'd4: r = a ^ b;
         3'd5: begin
            r = W'(ua * 2);
            c = a[W-1];
         end
         default: r = '0;
      endcase
      return {r, r[W-1], (r == '0), c, v};
   endfunction

   function automatic string res_req(input logic [2:0] code);
      case (code)
         3'd0: return "R1";
         3'd1: return "R3";
         3'd2, 3'd3, 3'd4: return "R6";
         3'd5: return "R7";
         default: return "R10";
      endcase
   endfunction

   function automatic string c_req(input logic [2:0] code);
      case (code)
         3'd0: return "R2";
         3'd1: return "R4";
         3'd2, 3'd3, 3'd4: return "R6";
         3'd5: return "R7";
         default: return "R10";
      endcase
   endfunction

   function automatic string v_req(input logic [2:0] code);
      case (code)
         3'd0, 3'd1: return "R5";
         3'd2, 3'd3, 3'd4: return "R6";
         3'd5: return "R7";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp,
                      input logic [2:0] code, input logic [W-1:0] a, input logic [W-1:0] b);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h", req, what, code, a, b, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] code, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W+3:0] e;
      @(posedge clk);
      op_sel = code; op_a = a; op_b = b;
      @(negedge clk);
      e = model(code, a, b);
      chk(res_req(code), "result", result, e[W+3:4], code, a, b);
      chk("R9", "flag_n", W'(flag_n), W'(e[3]), code, a, b);
      chk("R8", "flag_z", W'(flag_z), W'(e[2]), code, a, b);
      chk(c_req(code), "flag_c", W'(flag_c), W'(e[1]), code, a, b);
      chk(v_req(code), "flag_v", W'(flag_v), W'(e[0]), code, a, b);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog all-requirements actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // idle state: add of zeros gives zero result, Z set (R1, R8)
      apply(3'd0, 8'h00, 8'h00);
      // R2 carry without overflow
      apply(3'd0, 8'hFF, 8'h01);
      // R5 overflow without carry
      apply(3'd0, 8'h7F, 8'h01);
      // R2 and R5 both set
      apply(3'd0, 8'h80, 8'h80);
      // R4 borrow, R9 negative
      apply(3'd1, 8'h03, 8'h05);
      // R4 equal operands: no borrow, zero
      apply(3'd1, 8'h05, 8'h05);
      apply(3'd1, 8'h00, 8'h00);
      // R5 subtract overflow
      apply(3'd1, 8'h80, 8'h01);
      apply(3'd1, 8'h7F, 8'hFF);
      // R6 logic ops
      apply(3'd2, 8'hFF, 8'h00);
      apply(3'd3, 8'h80, 8'h01);
      apply(3'd4, 8'hA5, 8'hA5);
      // R7 shift
      apply(3'd5, 8'h80, 8'h00);
      apply(3'd5, 8'h40, 8'hFF);
      apply(3'd5, 8'hFF, 8'h00);
      // R10 unused codes
      apply(3'd6, 8'hFF, 8'hFF);
      apply(3'd7, 8'h80, 8'h7F);
      for (int code = 0; code < 8; code++) begin
         for (int k = 0; k < RAND_PER_CODE; k++) begin
            apply(3'(code), 8'($urandom), 8'($urandom));
         end
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule